// File: doc/BRIEF.md
# Paired DMA Channel Control Registers

This block is the register-side control plane for a set of DMA channel pairs. Each pair has one receive channel and one transmit channel. Software reaches the block over a plain 32-bit register bus that uses valid, write, address and data signals. The block decodes that bus into a global region and a row of fixed-size windows, one window per pair. Each window holds the descriptor-chain pointers for its two channels, their length fields, the receive enable and the receive row size. The global region holds an address-mode control bit and the interrupt logic.

The data movers sit outside this block, and so do descriptor fetch and the memory port. They see the block through its outputs: a level enable for each receive channel, a one-cycle start pulse for each transmit channel, and the pointers and row sizes they need. The movers report finished chains through a completion-event vector. Each event bit latches into a status register that software clears by writing ones. The status bits combine with a per-channel enable mask to form a read-only pending view, and any pending bit raises the single interrupt line.

Top module: `dmach_regs_top`

## Requirements
- R1: Pair k occupies a window at byte address 0x40*k. Its receive registers are addressed from the window base and its transmit registers from the base plus 0x18. Channel number 2k is the receive channel of pair k and 2k+1 is its transmit channel. This numbering is also the bit order in the status, enable and pending registers and in the completion-event input.
- R2: Each receive channel has six read/write registers, at window offsets 0x00 (pointer high), 0x04 (pointer low), 0x0C (length), 0x10 (block length), 0x14 (enable) and 0x30 (row size). The pointer, length, block length and row size registers keep all 32 bits. The pointer appears on `rx_desc_addr` as {high, low}, and the row size appears on `rx_row_bytes`.
- R3: Each transmit channel has four read/write 32-bit registers, at window offsets 0x18 (pointer high), 0x1C (pointer low), 0x24 (block length) and 0x2C (length). The pointer appears on `tx_desc_addr` as {high, low}.
- R4: A write to a transmit pointer-low register raises that pair's `tx_start` bit for exactly one cycle, in the cycle after the write. No other pair's bit rises.
- R5: Bit 0 of the receive enable register drives `rx_enable` of that pair, and writing 0 stops the channel. The register reads back only bit 0; all other bits read as zero.
- R6: The status register at 0x80000 sets bit n in the cycle after `done_evt[n]` is high. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: When a completion event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: The enable register at 0x80008 is read/write, one bit per channel. The register at 0x80004 reads as status AND enable, and writes to it have no effect.
- R9: `irq` is high exactly while status AND enable is nonzero. Writing 0 to the enable register drops `irq` and leaves the status bits as they were.
- R10: Bit 0 of the register at 0x34 selects 32-bit addressing. It drives `addr32_mode` and reads back as bit 0 only.
- R11: Any other address reads as zero, and a write to it changes no register or output. This includes offset 0x34 in windows other than pair 0, and windows at or beyond the pair count.
- R12: After reset, every register, `rx_enable`, `tx_start`, `addr32_mode`, `irq` and `bus_rvalid` are zero.
- R13: A read request presents its data on `bus_rdata` with `bus_rvalid` high in the cycle after the request. A write produces no `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W (20) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| done_evt | input | 2*NUM_PAIRS | Completion event per channel, ordered as in R1 |
| rx_enable | output | NUM_PAIRS | Receive channel run enable |
| tx_start | output | NUM_PAIRS | Transmit chain start pulse |
| rx_desc_addr | output | 64*NUM_PAIRS | Receive descriptor pointer per pair |
| tx_desc_addr | output | 64*NUM_PAIRS | Transmit descriptor pointer per pair |
| rx_row_bytes | output | 32*NUM_PAIRS | Receive row size per pair |
| addr32_mode | output | 1 | 32-bit addressing select |
| irq | output | 1 | Interrupt request |

## Verification
A write takes effect at the clock edge that samples it. Register contents, `rx_enable`, `addr32_mode` and `irq` therefore change in the cycle after the write, and `tx_start` is high only in that cycle. A completion event shows in the status register, and in `irq` when enabled, one cycle after it is driven. Read data lands one cycle after the request. The bench drives every stimulus on a falling edge, holds it across exactly one rising edge, and samples on the next falling edge. Each check therefore looks at the first cycle in which its result is due. The pulse check samples one more falling edge later to confirm the pulse is gone.

// File: rtl/dmach_pkg.sv
// Shared definitions for the paired DMA channel register block.
// Assumes byte addressing with 32-bit aligned registers.
package dmach_pkg;

    localparam int unsigned WIN_STRIDE_LOG2 = 6;     // 0x40 per pair window
    localparam int unsigned TX_BASE         = 'h18;  // transmit sub-window

    // Offsets inside a pair window
    localparam logic [5:0] O_RX_HI  = 6'h00;
    localparam logic [5:0] O_RX_LO  = 6'h04;
    localparam logic [5:0] O_RX_LEN = 6'h0C;
    localparam logic [5:0] O_RX_BLK = 6'h10;
    localparam logic [5:0] O_RX_EN  = 6'h14;
    localparam logic [5:0] O_RX_BPR = 6'h30;
    localparam logic [5:0] O_TX_HI  = 6'(TX_BASE + 'h00);
    localparam logic [5:0] O_TX_LO  = 6'(TX_BASE + 'h04);
    localparam logic [5:0] O_TX_BLK = 6'(TX_BASE + 'h0C);
    localparam logic [5:0] O_TX_LEN = 6'(TX_BASE + 'h14);
    localparam logic [5:0] O_ACR    = 6'h34;          // pair-0 window only

    // Global interrupt registers
    localparam logic [31:0] A_STAT = 32'h0008_0000;
    localparam logic [31:0] A_PEND = 32'h0008_0004;
    localparam logic [31:0] A_IEN  = 32'h0008_0008;

    typedef enum logic [3:0] {
        R_NONE, R_RX_HI, R_RX_LO, R_RX_LEN, R_RX_BLK, R_RX_EN, R_RX_BPR,
        R_TX_HI, R_TX_LO, R_TX_BLK, R_TX_LEN, R_ACR, R_STAT, R_PEND, R_IEN
    } reg_id_e;

    // True for identifiers that live in a pair window register file
    function automatic logic is_pair_reg(reg_id_e r);
        return (r inside {R_RX_HI, R_RX_LO, R_RX_LEN, R_RX_BLK, R_RX_EN,
                          R_RX_BPR, R_TX_HI, R_TX_LO, R_TX_BLK, R_TX_LEN});
    endfunction

endpackage

// File: rtl/dmach_addr_dec.sv
// Address decoder: maps a byte address to a register identifier and,
// for window registers, a pair index. Purely combinational.
// Assumes ADDR_W covers the global interrupt region (>= 20).
module dmach_addr_dec
    import dmach_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned NUM_PAIRS = 2,
    localparam int unsigned PW       = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
    localparam int unsigned WIN_W    = ADDR_W - WIN_STRIDE_LOG2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_id_e           reg_id,
    output logic [PW-1:0]     pair_idx
);

    logic [WIN_W-1:0] win;
    logic [5:0]       offs;
    logic             win_ok;

    assign win      = addr[ADDR_W-1:WIN_STRIDE_LOG2];
    assign offs     = addr[WIN_STRIDE_LOG2-1:0];
    assign win_ok   = (win < WIN_W'(NUM_PAIRS));
    assign pair_idx = PW'(win);

    // Classify the address into one register identifier
    always_comb begin
        reg_id = R_NONE;
        if (addr == ADDR_W'(A_STAT))      reg_id = R_STAT;
        else if (addr == ADDR_W'(A_PEND)) reg_id = R_PEND;
        else if (addr == ADDR_W'(A_IEN))  reg_id = R_IEN;
        else if (win_ok) begin
            unique case (offs)
                O_RX_HI:  reg_id = R_RX_HI;
                O_RX_LO:  reg_id = R_RX_LO;
                O_RX_LEN: reg_id = R_RX_LEN;
                O_RX_BLK: reg_id = R_RX_BLK;
                O_RX_EN:  reg_id = R_RX_EN;
                O_RX_BPR: reg_id = R_RX_BPR;
                O_TX_HI:  reg_id = R_TX_HI;
                O_TX_LO:  reg_id = R_TX_LO;
                O_TX_BLK: reg_id = R_TX_BLK;
                O_TX_LEN: reg_id = R_TX_LEN;
                O_ACR:    reg_id = (win == '0) ? R_ACR : R_NONE;
                default:  reg_id = R_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dmach_pair_regs.sv
// Register file of one receive/transmit channel pair. Holds descriptor
// pointers, lengths, receive enable and row size; emits a one-cycle
// transmit start after a pointer-low write. Read data is combinational.
// Assumes wr_en is already qualified by the pair select.
module dmach_pair_regs
    import dmach_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_id_e           reg_id,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_en,
    output logic              tx_start,
    output logic [2*DATA_W-1:0] rx_desc,
    output logic [2*DATA_W-1:0] tx_desc,
    output logic [DATA_W-1:0] rx_bpr
);

    logic [DATA_W-1:0] rx_hi_q, rx_lo_q, rx_len_q, rx_blk_q, rx_bpr_q;
    logic [DATA_W-1:0] tx_hi_q, tx_lo_q, tx_len_q, tx_blk_q;
    logic              rx_en_q, tx_start_q;

    // Register writes and the transmit start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_hi_q    <= '0; rx_lo_q  <= '0; rx_len_q <= '0;
            rx_blk_q   <= '0; rx_bpr_q <= '0; rx_en_q  <= 1'b0;
            tx_hi_q    <= '0; tx_lo_q  <= '0; tx_len_q <= '0;
            tx_blk_q   <= '0; tx_start_q <= 1'b0;
        end else begin
            tx_start_q <= wr_en && (reg_id == R_TX_LO);
            if (wr_en) begin
                case (reg_id)
                    R_RX_HI:  rx_hi_q  <= wdata;
                    R_RX_LO:  rx_lo_q  <= wdata;
                    R_RX_LEN: rx_len_q <= wdata;
                    R_RX_BLK: rx_blk_q <= wdata;
                    R_RX_EN:  rx_en_q  <= wdata[0];
                    R_RX_BPR: rx_bpr_q <= wdata;
                    R_TX_HI:  tx_hi_q  <= wdata;
                    R_TX_LO:  tx_lo_q  <= wdata;
                    R_TX_BLK: tx_blk_q <= wdata;
                    R_TX_LEN: tx_len_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // Read-back selection
    always_comb begin
        case (reg_id)
            R_RX_HI:  rd_data = rx_hi_q;
            R_RX_LO:  rd_data = rx_lo_q;
            R_RX_LEN: rd_data = rx_len_q;
            R_RX_BLK: rd_data = rx_blk_q;
            R_RX_EN:  rd_data = DATA_W'(rx_en_q);
            R_RX_BPR: rd_data = rx_bpr_q;
            R_TX_HI:  rd_data = tx_hi_q;
            R_TX_LO:  rd_data = tx_lo_q;
            R_TX_BLK: rd_data = tx_blk_q;
            R_TX_LEN: rd_data = tx_len_q;
            default:  rd_data = '0;
        endcase
    end

    assign rx_en    = rx_en_q;
    assign tx_start = tx_start_q;
    assign rx_desc  = {rx_hi_q, rx_lo_q};
    assign tx_desc  = {tx_hi_q, tx_lo_q};
    assign rx_bpr   = rx_bpr_q;

    // R4: a pointer-low write is followed by a start pulse
    p_tx_start_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_id == R_TX_LO) |=> tx_start);
    // R4: no start pulse without a pointer-low write just before
    p_tx_start_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(wr_en && reg_id == R_TX_LO));
    // R5: enable follows bit 0 of the written value
    p_rx_enable_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_id == R_RX_EN) |=> (rx_en == $past(wdata[0])));

endmodule

// File: rtl/dmach_irq_ctrl.sv
// Interrupt status, enable and pending logic. Status bits are set by
// completion events and cleared by writing ones; a same-cycle event wins.
// Assumes one status bit per channel, at most DATA_W channels.
module dmach_irq_ctrl #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] done_evt,
    input  logic           stat_wr,
    input  logic           ien_wr,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] stat,
    output logic [NCH-1:0] ien,
    output logic [NCH-1:0] pend,
    output logic           irq
);

    logic [NCH-1:0] stat_q, ien_q, clr_mask;

    assign clr_mask = stat_wr ? wdata : '0;

    // Status latch: set by event, cleared by write-one, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | done_evt;
    end

    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= wdata;
    end

    assign stat = stat_q;
    assign ien  = ien_q;
    assign pend = stat_q & ien_q;
    assign irq  = |pend;

    // R6, R7: every event is captured in the next cycle
    p_event_captured_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt != '0) |=> ((stat & $past(done_evt)) == $past(done_evt)));
    // R6: cleared bits without an event read as zero afterwards
    p_clear_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((stat & $past(wdata & ~done_evt)) == '0));
    // R9: zero enable silences the line
    p_ien_zero_silences_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr && wdata == '0) |=> !irq);
    // R9: disabling keeps status
    p_ien_keeps_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr && !stat_wr) |=> ((stat & $past(stat)) == $past(stat)));

endmodule

// File: rtl/dmach_regs_top.sv
// Control plane for paired DMA channels: bus decode, per-pair register
// files, global address-mode bit, interrupt logic and registered read path.
// Assumes single-cycle bus requests; reads return one cycle later.
module dmach_regs_top
    import dmach_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 2,
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned NCH      = 2 * NUM_PAIRS,
    localparam int unsigned PW       = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        bus_rvalid,
    input  logic [NCH-1:0]              done_evt,
    output logic [NUM_PAIRS-1:0]        rx_enable,
    output logic [NUM_PAIRS-1:0]        tx_start,
    output logic [2*DATA_W*NUM_PAIRS-1:0] rx_desc_addr,
    output logic [2*DATA_W*NUM_PAIRS-1:0] tx_desc_addr,
    output logic [DATA_W*NUM_PAIRS-1:0] rx_row_bytes,
    output logic                        addr32_mode,
    output logic                        irq
);

    reg_id_e           reg_id;
    logic [PW-1:0]     pair_idx;
    logic              wr_go, rd_go;
    logic [DATA_W-1:0] pair_rd [NUM_PAIRS];
    logic [NCH-1:0]    stat, ien, pend;
    logic              acr_q;
    logic [DATA_W-1:0] rd_mux, rdata_q;
    logic              rvalid_q;

    assign wr_go = bus_valid && bus_write;
    assign rd_go = bus_valid && !bus_write;

    dmach_addr_dec #(.ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS)) dec_i (
        .addr(bus_addr), .reg_id(reg_id), .pair_idx(pair_idx)
    );

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        logic pair_wr;
        assign pair_wr = wr_go && is_pair_reg(reg_id) && (pair_idx == PW'(k));
        dmach_pair_regs #(.DATA_W(DATA_W)) pair_i (
            .clk(clk), .rst_n(rst_n), .wr_en(pair_wr), .reg_id(reg_id),
            .wdata(bus_wdata), .rd_data(pair_rd[k]),
            .rx_en(rx_enable[k]), .tx_start(tx_start[k]),
            .rx_desc(rx_desc_addr[k*2*DATA_W +: 2*DATA_W]),
            .tx_desc(tx_desc_addr[k*2*DATA_W +: 2*DATA_W]),
            .rx_bpr(rx_row_bytes[k*DATA_W +: DATA_W])
        );
    end

    dmach_irq_ctrl #(.NCH(NCH)) irq_i (
        .clk(clk), .rst_n(rst_n), .done_evt(done_evt),
        .stat_wr(wr_go && reg_id == R_STAT), .ien_wr(wr_go && reg_id == R_IEN),
        .wdata(bus_wdata[NCH-1:0]), .stat(stat), .ien(ien), .pend(pend),
        .irq(irq)
    );

    // Global address-mode control bit
    always_ff @(posedge clk) begin
        if (!rst_n)                        acr_q <= 1'b0;
        else if (wr_go && reg_id == R_ACR) acr_q <= bus_wdata[0];
    end
    assign addr32_mode = acr_q;

    // Read data selection across all regions
    always_comb begin
        case (reg_id)
            R_ACR:   rd_mux = DATA_W'(acr_q);
            R_STAT:  rd_mux = DATA_W'(stat);
            R_PEND:  rd_mux = DATA_W'(pend);
            R_IEN:   rd_mux = DATA_W'(ien);
            R_NONE:  rd_mux = '0;
            default: rd_mux = pair_rd[pair_idx];
        endcase
    end

    // Registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_go;
            if (rd_go) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

    // R13: every read request is answered the next cycle
    p_read_answered_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> bus_rvalid);
    // R13: writes produce no response
    p_write_silent_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write) |=> !bus_rvalid);
    // R11: unmapped reads return zero
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && reg_id == R_NONE) |=> (bus_rdata == '0));
    // R11: unmapped writes leave the mode bit alone
    p_unmapped_keeps_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && reg_id == R_NONE) |=> $stable(addr32_mode));

endmodule

// File: tb/dmach_regs_top_tb.sv
// Directed bench for the paired DMA channel register block.
module dmach_regs_top_tb_top;

    localparam int NP  = 2;
    localparam int NCH = 2 * NP;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0, bus_write = 1'b0;
    logic [19:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NCH-1:0]    done_evt = '0;
    logic [NP-1:0]     rx_enable, tx_start;
    logic [64*NP-1:0]  rx_desc_addr, tx_desc_addr;
    logic [32*NP-1:0]  rx_row_bytes;
    logic              addr32_mode, irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    dmach_regs_top #(.NUM_PAIRS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .done_evt(done_evt), .rx_enable(rx_enable),
        .tx_start(tx_start), .rx_desc_addr(rx_desc_addr),
        .tx_desc_addr(tx_desc_addr), .rx_row_bytes(rx_row_bytes),
        .addr32_mode(addr32_mode), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One-cycle write; returns on the falling edge after the sampling edge
    task automatic bus_wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // One-cycle read; data is due one cycle after the request
    task automatic bus_rd(input logic [19:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        check("R13 rvalid", 64'(bus_rvalid), 64'd1);
        d = bus_rdata;
    endtask

    task automatic rd_expect(input string req, input logic [19:0] a, input logic [31:0] e);
        logic [31:0] d;
        bus_rd(a, d);
        check(req, 64'(d), 64'(e));
    endtask

    task automatic t_reset();
        check("R12 rx_enable", 64'(rx_enable), 64'd0);
        check("R12 tx_start", 64'(tx_start), 64'd0);
        check("R12 irq", 64'(irq), 64'd0);
        check("R12 addr32_mode", 64'(addr32_mode), 64'd0);
        check("R12 rvalid", 64'(bus_rvalid), 64'd0);
        rd_expect("R12 status", 20'h80000, 32'h0);
        rd_expect("R12 rx low pointer", 20'h04, 32'h0);
        rd_expect("R12 tx low pointer pair1", 20'h5C, 32'h0);
    endtask

    task automatic t_rx_regs();
        bus_wr(20'h00, 32'hA1A1_0001);
        bus_wr(20'h04, 32'hB2B2_0002);
        bus_wr(20'h0C, 32'h0000_1000);
        bus_wr(20'h10, 32'h0000_0200);
        bus_wr(20'h30, 32'h0000_0500);
        bus_wr(20'h44, 32'hCAFE_0044);   // pair 1 receive low pointer (R1)
        rd_expect("R2 rx high", 20'h00, 32'hA1A1_0001);
        rd_expect("R2 rx low", 20'h04, 32'hB2B2_0002);
        rd_expect("R2 rx length", 20'h0C, 32'h0000_1000);
        rd_expect("R2 rx block length", 20'h10, 32'h0000_0200);
        rd_expect("R2 rx row size", 20'h30, 32'h0000_0500);
        check("R2 rx_desc_addr pair0", rx_desc_addr[63:0], 64'hA1A1_0001_B2B2_0002);
        check("R2 rx_row_bytes pair0", 64'(rx_row_bytes[31:0]), 64'h500);
        check("R1 pair1 rx window", rx_desc_addr[127:64], 64'h0000_0000_CAFE_0044);
        check("R1 pair0 tx untouched", tx_desc_addr[63:0], 64'h0);
    endtask

    task automatic t_tx_regs();
        bus_wr(20'h58, 32'h0000_00AA);   // pair 1 transmit high
        check("R4 no pulse on high write", 64'(tx_start), 64'd0);
        bus_wr(20'h5C, 32'h1234_5678);   // pair 1 transmit low
        check("R4 start pulse pair1 only", 64'(tx_start), 64'b10);
        @(negedge clk);
        check("R4 pulse lasts one cycle", 64'(tx_start), 64'd0);
        bus_wr(20'h64, 32'h0000_0300);
        bus_wr(20'h6C, 32'h0000_0700);
        rd_expect("R3 tx high", 20'h58, 32'h0000_00AA);
        rd_expect("R3 tx block length", 20'h64, 32'h0000_0300);
        rd_expect("R3 tx length", 20'h6C, 32'h0000_0700);
        check("R3 tx_desc_addr pair1", tx_desc_addr[127:64], 64'h0000_00AA_1234_5678);
        bus_wr(20'h1C, 32'h0000_0010);
        check("R4 start pulse pair0 only", 64'(tx_start), 64'b01);
    endtask

    task automatic t_rx_enable();
        bus_wr(20'h14, 32'hFFFF_FFFF);
        check("R5 rx_enable set", 64'(rx_enable), 64'b01);
        rd_expect("R5 enable reads bit0 only", 20'h14, 32'h1);
        bus_wr(20'h14, 32'h0);
        check("R5 rx_enable stopped", 64'(rx_enable), 64'b00);
    endtask

    task automatic t_interrupts();
        @(negedge clk); done_evt = 4'b1000;
        @(negedge clk); done_evt = '0;
        check("R9 irq masked", 64'(irq), 64'd0);
        rd_expect("R6 status bit3", 20'h80000, 32'h8);
        rd_expect("R8 pending masked", 20'h80004, 32'h0);
        bus_wr(20'h80008, 32'h0000_000C);
        check("R9 irq raised", 64'(irq), 64'd1);
        rd_expect("R8 enable readback", 20'h80008, 32'hC);
        rd_expect("R8 pending", 20'h80004, 32'h8);
        bus_wr(20'h80008, 32'h0);
        check("R9 irq silenced", 64'(irq), 64'd0);
        rd_expect("R9 status kept", 20'h80000, 32'h8);
        bus_wr(20'h80000, 32'h0000_0004);
        rd_expect("R6 write of other bit keeps status", 20'h80000, 32'h8);
        bus_wr(20'h80000, 32'h0000_0008);
        rd_expect("R6 cleared", 20'h80000, 32'h0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk); done_evt = 4'b0001;
        @(negedge clk); done_evt = '0;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 20'h80000;
        bus_wdata = 32'h3; done_evt = 4'b0010;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; done_evt = '0;
        rd_expect("R7 event beats clear", 20'h80000, 32'h2);
        bus_wr(20'h80000, 32'h2);
    endtask

    task automatic t_mode();
        bus_wr(20'h34, 32'hFFFF_FFFF);
        check("R10 addr32_mode set", 64'(addr32_mode), 64'd1);
        rd_expect("R10 readback bit0", 20'h34, 32'h1);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_wr(20'h74, 32'h0);            // offset 0x34 of pair 1
        check("R11 pair1 0x34 ignored", 64'(addr32_mode), 64'd1);
        rd_expect("R11 pair1 0x34 reads zero", 20'h74, 32'h0);
        bus_wr(20'h84, 32'hDEAD_BEEF);    // pair 2 does not exist
        rd_expect("R11 out-of-range window", 20'h84, 32'h0);
        rd_expect("R11 gap offset", 20'h08, 32'h0);
        rd_expect("R11 offset 0x38", 20'h38, 32'h0);
        bus_wr(20'h80008, 32'h1);
        @(negedge clk); done_evt = 4'b0001;
        @(negedge clk); done_evt = '0;
        bus_wr(20'h80004, 32'h0);         // pending is read-only
        check("R8 pending write ignored", 64'(irq), 64'd1);
        rd_expect("R8 pending unchanged", 20'h80004, 32'h1);
        check("R11 pair0 pointers unchanged", rx_desc_addr[63:0], 64'hA1A1_0001_B2B2_0002);
        bus_wr(20'h80000, 32'h1);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 20'h10; bus_wdata = 32'h9;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check("R13 write gives no rvalid", 64'(bus_rvalid), 64'd0);
        bus_rd(20'h10, d);
        check("R2 block length rewritten", 64'(d), 64'h9);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_regs();
        t_tx_regs();
        t_rx_enable();
        t_interrupts();
        t_same_cycle();
        t_mode();
        t_unmapped();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule